// File: doc/BRIEF.md
# Serial Framed Display Column Memory

This block is a synchronous serial slave that gives a host read and write access to a small display memory of 24 columns by 8 rows. The host opens a frame by pulling chip select low while the serial clock is low. It then clocks in a header of 5 address bits and one direction bit, followed by 24 data bits. The 24 data bits cover three neighbouring columns. Within the frame the column pointer steps forward on its own, and it wraps from the last column back to column 0. One reserved address does not reach the memory. Writing to it loads a small configuration register that holds a backplane-count code and a master/slave flag.

All serial pins are sampled by a fast system clock, and the block finds the serial clock edges from those samples. Data is taken in on serial clock rises. Read data is put out on serial clock falls through an open-drain style output: the block either pulls the shared line low or releases it. A display scanner reads the memory through an independent combinational column port. The scanner also uses the configuration outputs and a busy flag that is high while a frame is being transferred.

Top module: `serial_dispram`

## Requirements
- R1: At reset, busy=0, sdo_pull_low=0, cfg_bp_code=3'b111 and cfg_master=1. A frame starts when chip select falls while the serial clock is low. busy rises at that point, stays 1 until the 30th serial clock rise of the frame, and is 0 from then on. The frame does not depend on chip select after its first rise.
- R2: A falling edge on chip select has no effect while the serial clock is high. No frame starts, busy stays 0, and later serial clock pulses change neither the memory nor the configuration.
- R3: A falling edge on chip select while a frame is in progress is ignored. The current frame goes on and completes as if the edge had not happened.
- R4: The first 5 bits of a frame are the start column address, most significant bit first. The sixth bit gives the direction: 1 means read and 0 means write.
- R5: In each group of 8 data bits, the first bit belongs to row 1 and the eighth bit belongs to row 8. On scan_data, row r appears at bit r-1. A write changes a column only once all 8 of its bits have been received.
- R6: The column pointer steps forward after the 8th data bit and again after the 16th. It goes from column 23 to column 0, so start address 22 covers columns 22, 23, 0 and start address 23 covers columns 23, 0, 1.
- R7: During the data bits of a read frame, each bit is presented after a serial clock fall, in the same order as in R5. sdo_pull_low=1 stands for a 0 bit and sdo_pull_low=0 stands for a 1 bit. At all other times the line is released (sdo_pull_low=0), including for the whole of a write frame.
- R8: A write frame to address 24 (binary 11000) loads the configuration. Data bits 1 to 3 give cfg_bp_code[2], [1] and [0], and data bit 4 gives cfg_master. The other 20 bits are ignored, and the memory is not changed.
- R9: A write frame to any address from 25 to 31 leaves the memory and the configuration unchanged. A read frame from any address from 24 to 31 returns 24 one bits.
- R10: The memory contents and the configuration outputs change only while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial pin |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; its falling edge opens a frame |
| sdi | input | 1 | Serial data in, sampled on serial clock rises |
| sdo_pull_low | output | 1 | 1 = pull the shared data-out line low; 0 = release it |
| busy | output | 1 | High while a frame is being transferred |
| cfg_bp_code | output | 3 | Backplane-count code from the configuration register |
| cfg_master | output | 1 | Master/slave flag from the configuration register |
| scan_col | input | 5 | Column index on the scanner read port |
| scan_data | output | 8 | Contents of the scanner column; bit 0 is row 1 |

## Verification
The pointer step that ends one column group happens on the same serial clock rise as the write of that column. On a read, it also coincides with fetching the next column, so the bench sweeps the start address over all 24 columns and includes starts at 22 and 23. This forces the write-back and the wrap from column 23 to 0 onto a single edge. Each column read back through the scanner port and each bit returned on the data-out line is compared with a model column computed in the bench. A second collision is a chip select edge that arrives while a frame is in progress. It is provoked by driving a chip select pulse in the middle of a write frame, and it passes only if the memory ends up holding exactly the data that frame carried.

// File: rtl/dspram_pkg.sv
package dspram_pkg;

  typedef struct packed {
    logic [2:0] bp_code;
    logic       master;
  } panel_cfg_t;

  localparam panel_cfg_t CFG_RESET = '{bp_code: 3'b111, master: 1'b1};

endpackage

// File: rtl/dspram_edges.sv
module dspram_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_req
);

  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  // a select edge counts only while the serial clock stays low
  assign frame_req = cs_q & ~cs_n & ~sclk & ~sclk_q;

endmodule

// File: rtl/dspram_seq.sv
module dspram_seq #(
  parameter int ADDR_W = 5,
  parameter int ROWS   = 8,
  parameter int SPAN   = 3,
  parameter int COLS   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              frame_req,
  input  logic              sdi,
  output logic              active,
  output logic              in_data,
  output logic              data_step,
  output logic              hdr_strobe,
  output logic              grp_strobe,
  output logic              cfg_strobe,
  output logic              rw,
  output logic              col_valid,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_next
);

  localparam int HDR   = ADDR_W + 1;
  localparam int FRAME = HDR + SPAN * ROWS;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int SEL_W = $clog2(ROWS);
  localparam int GRP_W = (SPAN > 1) ? $clog2(SPAN) : 1;

  localparam logic [CNT_W-1:0] CNT_ADDR_END = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR - 1);
  localparam logic [CNT_W-1:0] CNT_DATA     = CNT_W'(HDR);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME - 1);
  localparam logic [SEL_W-1:0] SEL_LAST     = SEL_W'(ROWS - 1);
  localparam logic [SEL_W-1:0] SEL_CFG      = SEL_W'(3);
  localparam logic [GRP_W-1:0] GRP_LAST     = GRP_W'(SPAN - 1);

  logic              act_q, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              step;

  assign step      = act_q & sclk_rise;
  assign in_data   = act_q & (cnt_q >= CNT_DATA);
  assign ptr_next  = (ptr_q == ADDR_W'(COLS - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    grp_d  = grp_q;
    addr_d = addr_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    if (!act_q) begin
      if (frame_req) begin
        act_d = 1'b1;
        cnt_d = '0;
        sel_d = '0;
        grp_d = '0;
      end
    end else if (sclk_rise) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CNT_ADDR_END) addr_d = {addr_q[ADDR_W-2:0], sdi};
      if (cnt_q == CNT_HDR_LAST) begin
        rw_d  = sdi;
        ptr_d = addr_q;
      end
      if (in_data) begin
        if (sel_q == SEL_LAST) begin
          sel_d = '0;
          grp_d = grp_q + 1'b1;
          if (grp_q != GRP_LAST) ptr_d = ptr_next;
        end else begin
          sel_d = sel_q + 1'b1;
        end
      end
      if (cnt_q == CNT_LAST) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
      grp_q  <= '0;
      addr_q <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      grp_q  <= grp_d;
      addr_q <= addr_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
    end
  end

  assign active     = act_q;
  assign data_step  = step & in_data;
  assign hdr_strobe = step & (cnt_q == CNT_HDR_LAST);
  assign grp_strobe = data_step & (sel_q == SEL_LAST);
  assign cfg_strobe = data_step & (grp_q == '0) & (sel_q == SEL_CFG);
  assign rw         = rw_q;
  assign col_valid  = {1'b0, addr_q} < (ADDR_W + 1)'(COLS);
  assign addr       = addr_q;
  assign ptr        = ptr_q;

endmodule

// File: rtl/dspram_cols.sv
module dspram_cols #(
  parameter int COLS   = 24,
  parameter int ROWS   = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ROWS-1:0]   wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [ROWS-1:0]   rdata_a,
  output logic [ROWS-1:0]   rdata_b
);

  logic [ROWS-1:0] mem [COLS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = ({1'b0, raddr_a} < (ADDR_W + 1)'(COLS)) ? mem[raddr_a] : '1;
  assign rdata_b = ({1'b0, raddr_b} < (ADDR_W + 1)'(COLS)) ? mem[raddr_b] : '1;

endmodule

// File: rtl/serial_dispram.sv
module serial_dispram
  import dspram_pkg::*;
#(
  parameter int COLS     = 24,
  parameter int ROWS     = 8,
  parameter int ADDR_W   = 5,
  parameter int SPAN     = 3,
  parameter int CFG_ADDR = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo_pull_low,
  output logic              busy,
  output logic [2:0]        cfg_bp_code,
  output logic              cfg_master,
  input  logic [ADDR_W-1:0] scan_col,
  output logic [ROWS-1:0]   scan_data
);

  logic [1:0] rst_sync;
  logic       rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core = rst_sync[1];

  logic              sclk_rise, sclk_fall, frame_req;
  logic              active, in_data, data_step, hdr_strobe, grp_strobe, cfg_strobe;
  logic              rw, col_valid;
  logic [ADDR_W-1:0] addr, ptr, ptr_next, rd_col;
  logic [ROWS-1:0]   rd_data, shift_in;
  logic              we;

  dspram_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_core),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .frame_req (frame_req)
  );

  dspram_seq #(.ADDR_W(ADDR_W), .ROWS(ROWS), .SPAN(SPAN), .COLS(COLS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core),
    .sclk_rise  (sclk_rise),
    .frame_req  (frame_req),
    .sdi        (sdi),
    .active     (active),
    .in_data    (in_data),
    .data_step  (data_step),
    .hdr_strobe (hdr_strobe),
    .grp_strobe (grp_strobe),
    .cfg_strobe (cfg_strobe),
    .rw         (rw),
    .col_valid  (col_valid),
    .addr       (addr),
    .ptr        (ptr),
    .ptr_next   (ptr_next)
  );

  logic [ROWS-1:0] sh_q, sh_d;
  panel_cfg_t      cfg_q, cfg_d;
  logic            sdo_q, sdo_d;

  assign shift_in = {sdi, sh_q[ROWS-1:1]};
  assign rd_col   = hdr_strobe ? addr : ptr_next;
  assign we       = grp_strobe & ~rw & col_valid;

  dspram_cols #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_cols (
    .clk     (clk),
    .we      (we),
    .waddr   (ptr),
    .wdata   (shift_in),
    .raddr_a (rd_col),
    .raddr_b (scan_col),
    .rdata_a (rd_data),
    .rdata_b (scan_data)
  );

  // one register assembles write columns and holds the column being read
  always_comb begin
    sh_d = sh_q;
    if (hdr_strobe || grp_strobe) sh_d = col_valid ? rd_data : '1;
    else if (data_step)           sh_d = shift_in;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_strobe && !rw && (addr == ADDR_W'(CFG_ADDR)))
      cfg_d = '{bp_code: {sh_q[ROWS-3], sh_q[ROWS-2], sh_q[ROWS-1]}, master: sdi};
  end

  always_comb begin
    sdo_d = sdo_q;
    if (sclk_fall) sdo_d = (active && rw && in_data) ? sh_q[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      sh_q  <= '1;
      cfg_q <= CFG_RESET;
      sdo_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo_pull_low = ~sdo_q;
  assign busy         = active;
  assign cfg_bp_code  = cfg_q.bp_code;
  assign cfg_master   = cfg_q.master;

endmodule

// File: rtl/dspram_chk.sv
module dspram_chk #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              cs_n,
  input logic              sdo_pull_low,
  input logic              busy,
  input logic [2:0]        cfg_bp_code,
  input logic              cfg_master,
  input logic [ADDR_W-1:0] scan_col,
  input logic [ROWS-1:0]   scan_data
);

  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk;
  end

  assert_start_on_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs_n));

  assert_start_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!sclk));

  assert_out_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_pull_low) |-> ($past(!sclk) && $past(sclk_d)));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy) |-> $stable({cfg_bp_code, cfg_master}));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy) && $stable(scan_col)) |-> $stable(scan_data));

endmodule

bind serial_dispram dspram_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sclk         (sclk),
  .cs_n         (cs_n),
  .sdo_pull_low (sdo_pull_low),
  .busy         (busy),
  .cfg_bp_code  (cfg_bp_code),
  .cfg_master   (cfg_master),
  .scan_col     (scan_col),
  .scan_data    (scan_data)
);

// File: tb/test_serial_dispram.sv
module test_serial_dispram;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdi = 1'b0;
  logic [4:0] scan_col = '0;
  logic       sdo_pull_low, busy, cfg_master;
  logic [2:0] cfg_bp_code;
  logic [7:0] scan_data;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] model [24];

  always #2 clk = ~clk;

  serial_dispram i_serial_dispram (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo_pull_low(sdo_pull_low), .busy(busy), .cfg_bp_code(cfg_bp_code),
    .cfg_master(cfg_master), .scan_col(scan_col), .scan_data(scan_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int c);
    return (c == 23) ? 0 : c + 1;
  endfunction

  task automatic frame(input logic [4:0] a, input bit rd, input logic [23:0] d,
                       output logic [23:0] q, input bit glitch);
    bit pulled = 1'b0;
    q = '0;
    cs_n = 1'b0;
    tick(2);
    chk("R1 busy after start", busy, 1);
    for (int i = 0; i < 30; i++) begin
      if (i < 5)       sdi = a[4-i];
      else if (i == 5) sdi = rd;
      else             sdi = d[i-6];
      tick(2);
      if (i >= 6) q[i-6] = ~sdo_pull_low;
      if (sdo_pull_low) pulled = 1'b1;
      if (i == 29) chk("R1 busy before last bit", busy, 1);
      sclk = 1'b1;
      tick(2);
      if (i == 0) cs_n = 1'b1;
      sclk = 1'b0;
      if (glitch && i == 10) begin
        tick(1);
        cs_n = 1'b0;
        tick(2);
        cs_n = 1'b1;
      end
    end
    tick(2);
    chk("R1 busy after last bit", busy, 0);
    if (!rd) chk("R7 line released in write", pulled, 0);
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic check_mem(input string tag);
    for (int c = 0; c < 24; c++) begin
      scan_col = 5'(c);
      tick(1);
      chk(tag, scan_data, model[c]);
    end
  endtask

  task automatic write3(input int s, input logic [7:0] a0, input logic [7:0] a1,
                        input logic [7:0] a2, input bit glitch);
    logic [23:0] q;
    frame(5'(s), 1'b0, {a2, a1, a0}, q, glitch);
    model[s] = a0;
    model[nxt(s)] = a1;
    model[nxt(nxt(s))] = a2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [23:0] q;
    logic [23:0] e;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 / R8 reset state
    chk("R1 reset busy", busy, 0);
    chk("R1 reset line", sdo_pull_low, 0);
    chk("R8 reset bp code", cfg_bp_code, 3'b111);
    chk("R8 reset master", cfg_master, 1);

    // R4 R5: fill every column with a computed pattern
    for (int s = 0; s < 24; s += 3)
      write3(s, 8'((s * 37) + 5), 8'(((s + 1) * 37) + 5), 8'(((s + 2) * 37) + 5), 1'b0);
    check_mem("R5 write fill");

    // R6 R7: read from every start column, wrap included
    for (int s = 0; s < 24; s++) begin
      frame(5'(s), 1'b1, 24'h0, q, 1'b0);
      e = {model[nxt(nxt(s))], model[nxt(s)], model[s]};
      chk($sformatf("R7 read start %0d", s), q, e);
    end

    // R6 write wrap from 22 and 23
    write3(22, 8'hA5, 8'h3C, 8'h81, 1'b0);
    check_mem("R6 write wrap start 22");
    write3(23, 8'h0F, 8'hF0, 8'h5A, 1'b0);
    check_mem("R6 write wrap start 23");

    // R3 select pulse during a frame
    write3(9, 8'h12, 8'h34, 8'h56, 1'b1);
    check_mem("R3 mid-frame select ignored");

    // R8 configuration loads
    frame(5'd24, 1'b0, {20'hFFFFF, 4'b0010}, q, 1'b0);
    chk("R8 bp code 010", cfg_bp_code, 3'b010);
    chk("R8 master 0", cfg_master, 0);
    frame(5'd24, 1'b0, {20'h00000, 4'b1101}, q, 1'b0);
    chk("R8 bp code 101", cfg_bp_code, 3'b101);
    chk("R8 master 1", cfg_master, 1);
    check_mem("R8 memory untouched by config");

    // R9 unused addresses
    for (int a = 25; a < 32; a++) begin
      frame(5'(a), 1'b0, 24'h000000, q, 1'b0);
      chk("R9 config untouched bp", cfg_bp_code, 3'b101);
    end
    check_mem("R9 memory untouched by unused writes");
    for (int a = 24; a < 32; a++) begin
      frame(5'(a), 1'b1, 24'h0, q, 1'b0);
      chk($sformatf("R9 read unused %0d", a), q, 24'hFFFFFF);
    end

    // R2 select falling while serial clock is high
    sclk = 1'b1;
    tick(2);
    cs_n = 1'b0;
    tick(2);
    chk("R2 no frame on high clock", busy, 0);
    for (int i = 0; i < 30; i++) begin
      sclk = 1'b0;
      sdi = (i == 5) ? 1'b0 : 1'b1;
      tick(2);
      chk("R2 busy stays low", busy, 0);
      sclk = 1'b1;
      tick(2);
    end
    sclk = 1'b0;
    tick(2);
    cs_n = 1'b1;
    tick(4);
    check_mem("R2 memory untouched");
    chk("R2 config untouched", cfg_bp_code, 3'b101);

    // R10 after all activity a last read still matches
    frame(5'd0, 1'b1, 24'h0, q, 1'b0);
    chk("R10 final read", q, {model[2], model[1], model[0]});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule